// File: doc/BRIEF.md
# Dual-Width Signed Divider with Trap

This block divides a signed double-length dividend by a signed single-length divisor and returns a single-length quotient and remainder. A mode input picks the width of each operation when it starts. In narrow mode the dividend is 16 bits and the divisor is 8 bits. In wide mode the dividend is 32 bits, split across a high and a low input word, and the divisor is 16 bits. The quotient is truncated toward zero. A nonzero remainder takes the sign of the dividend.

The quotient must lie in a symmetric signed range: ±127 in narrow mode and ±32767 in wide mode. When the true quotient falls outside that range, or the divisor is zero, the block raises a one-cycle divide-error trap and leaves its result outputs as they were. The surrounding core takes the trap and handles exception entry. The block itself never does that.

The datapath is a restoring shift-subtract loop that works on magnitudes and produces one quotient bit per cycle. The signs are applied in a final cycle, and the range check is made in the same cycle. A zero divisor is caught on the accepting clock edge and trapped at once, without running the loop.

Top module: `dual_width_sdiv`

## Requirements
- R1: Narrow mode (`wide`=0) uses only bits [7:0] of `dividend_hi`, `dividend_lo` and `divisor`. The dividend is {dividend_hi[7:0], dividend_lo[7:0]} in two's complement. The quotient appears in `quotient`[7:0] and the remainder in `remainder`[7:0]. Bits [15:8] of both outputs read zero after a narrow result.
- R2: Wide mode (`wide`=1) divides the 32-bit two's-complement value {dividend_hi, dividend_lo} by the 16-bit `divisor`. The quotient is driven on `quotient` and the remainder on `remainder`.
- R3: The quotient is truncated toward zero. A nonzero remainder has the sign of the dividend. Dividend = quotient × divisor + remainder.
- R4: Quotients from -127 to +127 (narrow) and from -32767 to +32767 (wide) are delivered. A true quotient outside that range, including -128 and -32768, raises `trap` instead of `done`.
- R5: A divisor that is zero in the selected width raises `trap` in the cycle right after the accepting edge. `busy` stays low. In narrow mode, nonzero bits [15:8] of `divisor` do not prevent this trap.
- R6: After a trap, `quotient` and `remainder` keep the values they held before it.
- R7: With a nonzero divisor, `busy` goes high after the accepting edge and stays high for N+1 cycles, where N is 8 in narrow mode and 16 in wide mode. `done` or `trap` appears in the cycle in which `busy` falls.
- R8: `done` and `trap` are never high together. Each completion raises its pulse for one cycle only.
- R9: `start` is ignored while `busy` is high, including in the finishing cycle. Operands that change during that time do not affect the running operation.
- R10: After reset, `busy`, `done` and `trap` are low, and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken when `busy` is low |
| wide | input | 1 | 1 = 32/16 division, 0 = 16/8 division |
| dividend_hi | input | 16 | Upper half of the dividend |
| dividend_lo | input | 16 | Lower half of the dividend |
| divisor | input | 16 | Divisor (low byte only in narrow mode) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| trap | output | 1 | One-cycle pulse: divide error |
| quotient | output | 16 | Signed quotient |
| remainder | output | 16 | Signed remainder |

## Verification
Two events can fall in the same cycle. The first is the completion cycle, which raises `done` or `trap`, and the second is a fresh `start` request. The bench holds `start` high with new operands right through the finishing edge and one edge beyond it. The behavioural model then expects the finishing cycle to ignore the request and the next edge to accept it, with the first result still delivered intact. Back-to-back zero-divisor requests make `trap` fire on successive cycles, and the model expects the result outputs to stay frozen throughout.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    // Sequencer states of the divider
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sdiv_state_e;

endpackage

// File: rtl/sdiv_operand_prep.sv
// Turns signed operands of the selected width into magnitudes and sign bits.
// The low half of the dividend magnitude is left-aligned so that the
// iteration loop always shifts bits out of the top position.
module sdiv_operand_prep #(
    parameter int HALF_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              wide,
    input  logic [HALF_W-1:0] dvd_hi,
    input  logic [HALF_W-1:0] dvd_lo,
    input  logic [HALF_W-1:0] dvs,
    output logic              dvd_neg,
    output logic              dvs_neg,
    output logic [HALF_W-1:0] hi_mag,
    output logic [HALF_W-1:0] lo_mag,
    output logic [HALF_W-1:0] dvs_mag,
    output logic              dvs_zero
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int NDW    = 2 * NARROW_W;

    logic [NDW-1:0]      narrow_dvd;
    logic [FULL_W-1:0]   dvd_ext;
    logic [HALF_W-1:0]   dvs_ext;
    logic [FULL_W-1:0]   dvd_mag;

    always_comb begin
        narrow_dvd = {dvd_hi[NARROW_W-1:0], dvd_lo[NARROW_W-1:0]};
        if (wide) begin
            dvd_ext = {dvd_hi, dvd_lo};
            dvs_ext = dvs;
        end else begin
            dvd_ext = {{(FULL_W-NDW){narrow_dvd[NDW-1]}}, narrow_dvd};
            dvs_ext = {{(HALF_W-NARROW_W){dvs[NARROW_W-1]}}, dvs[NARROW_W-1:0]};
        end
        dvd_neg  = dvd_ext[FULL_W-1];
        dvs_neg  = dvs_ext[HALF_W-1];
        dvd_mag  = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
        dvs_mag  = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
        dvs_zero = (dvs_ext == '0);
        if (wide) begin
            hi_mag = dvd_mag[FULL_W-1:HALF_W];
            lo_mag = dvd_mag[HALF_W-1:0];
        end else begin
            hi_mag = HALF_W'(dvd_mag[NDW-1:NARROW_W]);
            lo_mag = {dvd_mag[NARROW_W-1:0], {(HALF_W-NARROW_W){1'b0}}};
        end
    end

endmodule

// File: rtl/sdiv_restore_step.sv
// One restoring shift-subtract step on unsigned magnitudes.
module sdiv_restore_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic         qbit_o
);
    logic [W:0]   trial;
    logic [W-1:0] diff;

    always_comb begin
        trial  = {rem_i, bit_i};
        qbit_o = (trial >= {1'b0, dvs_i});
        // When the subtraction is taken the result is below dvs_i, so the
        // low W bits suffice.
        diff   = trial[W-1:0] - dvs_i;
        rem_o  = qbit_o ? diff : trial[W-1:0];
    end

endmodule

// File: rtl/dual_width_sdiv.sv
module dual_width_sdiv
    import sdiv_pkg::*;
#(
    parameter int HALF_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [HALF_W-1:0] dividend_hi,
    input  logic [HALF_W-1:0] dividend_lo,
    input  logic [HALF_W-1:0] divisor,
    output logic              busy,
    output logic              done,
    output logic              trap,
    output logic [HALF_W-1:0] quotient,
    output logic [HALF_W-1:0] remainder
);
    localparam int CNT_W = $clog2(HALF_W + 1);
    localparam logic [HALF_W-1:0] WIDE_MAX    = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] NARROW_MAX  = HALF_W'({1'b0, {(NARROW_W-1){1'b1}}});
    localparam logic [HALF_W-1:0] NARROW_MASK = HALF_W'({NARROW_W{1'b1}});
    localparam logic [HALF_W-1:0] WIDE_MIN    = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [HALF_W-1:0] NARROW_MIN  = HALF_W'({1'b1, {(NARROW_W-1){1'b0}}});
    localparam logic [CNT_W-1:0]  WIDE_ITERS   = CNT_W'(HALF_W);
    localparam logic [CNT_W-1:0]  NARROW_ITERS = CNT_W'(NARROW_W);

    typedef struct packed {
        sdiv_state_e       st;
        logic              wide;
        logic              dvd_neg;
        logic              q_neg;
        logic              too_big;
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] rem;
        logic [HALF_W-1:0] lo_sh;
        logic [HALF_W-1:0] q_sh;
        logic [HALF_W-1:0] dvs;
        logic [HALF_W-1:0] quo_out;
        logic [HALF_W-1:0] rem_out;
        logic              done;
        logic              trap;
    } sdiv_regs_t;

    sdiv_regs_t r_q, r_d;

    // Operand preparation
    logic              p_dvd_neg;
    logic              p_dvs_neg;
    logic [HALF_W-1:0] p_hi_mag;
    logic [HALF_W-1:0] p_lo_mag;
    logic [HALF_W-1:0] p_dvs_mag;
    logic              p_dvs_zero;

    sdiv_operand_prep #(
        .HALF_W   (HALF_W),
        .NARROW_W (NARROW_W)
    ) prep_i (
        .wide     (wide),
        .dvd_hi   (dividend_hi),
        .dvd_lo   (dividend_lo),
        .dvs      (divisor),
        .dvd_neg  (p_dvd_neg),
        .dvs_neg  (p_dvs_neg),
        .hi_mag   (p_hi_mag),
        .lo_mag   (p_lo_mag),
        .dvs_mag  (p_dvs_mag),
        .dvs_zero (p_dvs_zero)
    );

    // Iteration step
    logic [HALF_W-1:0] s_rem;
    logic              s_qbit;

    sdiv_restore_step #(
        .W (HALF_W)
    ) step_i (
        .rem_i  (r_q.rem),
        .bit_i  (r_q.lo_sh[HALF_W-1]),
        .dvs_i  (r_q.dvs),
        .rem_o  (s_rem),
        .qbit_o (s_qbit)
    );

    // Sign application and range check on the magnitude quotient
    logic [HALF_W-1:0] q_signed;
    logic [HALF_W-1:0] r_signed;
    logic [HALF_W-1:0] q_limit;
    logic              overflow;

    always_comb begin
        q_signed = r_q.q_neg   ? (~r_q.q_sh + 1'b1) : r_q.q_sh;
        r_signed = r_q.dvd_neg ? (~r_q.rem  + 1'b1) : r_q.rem;
        if (!r_q.wide) begin
            q_signed = q_signed & NARROW_MASK;
            r_signed = r_signed & NARROW_MASK;
        end
        q_limit  = r_q.wide ? WIDE_MAX : NARROW_MAX;
        overflow = r_q.too_big || (r_q.q_sh > q_limit);
    end

    // Next-state computation
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.trap = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (p_dvs_zero) begin
                        r_d.trap = 1'b1;
                    end else begin
                        r_d.st      = ST_RUN;
                        r_d.wide    = wide;
                        r_d.dvd_neg = p_dvd_neg;
                        r_d.q_neg   = p_dvd_neg ^ p_dvs_neg;
                        r_d.too_big = (p_hi_mag >= p_dvs_mag);
                        r_d.cnt     = wide ? WIDE_ITERS : NARROW_ITERS;
                        r_d.rem     = p_hi_mag;
                        r_d.lo_sh   = p_lo_mag;
                        r_d.q_sh    = '0;
                        r_d.dvs     = p_dvs_mag;
                    end
                end
            end
            ST_RUN: begin
                r_d.rem   = s_rem;
                r_d.lo_sh = {r_q.lo_sh[HALF_W-2:0], 1'b0};
                r_d.q_sh  = {r_q.q_sh[HALF_W-2:0], s_qbit};
                r_d.cnt   = r_q.cnt - CNT_W'(1);
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
                if (overflow) begin
                    r_d.trap = 1'b1;
                end else begin
                    r_d.quo_out = q_signed;
                    r_d.rem_out = r_signed;
                    r_d.done    = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign trap      = r_q.trap;
    assign quotient  = r_q.quo_out;
    assign remainder = r_q.rem_out;

    // ---------------- assertions ----------------
    logic sel_zero;
    logic rem_msb;
    logic [HALF_W-1:0] min_code;

    always_comb begin
        sel_zero = wide ? (divisor == '0) : (divisor[NARROW_W-1:0] == '0);
        rem_msb  = r_q.wide ? remainder[HALF_W-1] : remainder[NARROW_W-1];
        min_code = r_q.wide ? WIDE_MIN : NARROW_MIN;
    end

    p_narrow_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r_q.wide) |-> (quotient[HALF_W-1:NARROW_W] == '0 && remainder[HALF_W-1:NARROW_W] == '0));

    p_rem_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && remainder != '0) |-> (rem_msb == r_q.dvd_neg));

    p_no_min_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quotient != min_code));

    p_zero_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && sel_zero) |=> (trap && !busy));

    p_hold_on_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> ($stable(quotient) && $stable(remainder)));

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !sel_zero) |=> busy);

    p_idle_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done || trap) |-> !busy);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && trap));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && r_q.st == ST_RUN) |=> $stable(r_q.dvs));

endmodule

// File: tb/dual_width_sdiv_tb.sv
module dual_width_sdiv_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [15:0] dividend_hi = '0;
    logic [15:0] dividend_lo = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, trap;
    logic [15:0] quotient, remainder;

    always #10 clk = ~clk;  // 50 MHz

    dual_width_sdiv dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .wide        (wide),
        .dividend_hi (dividend_hi),
        .dividend_lo (dividend_lo),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .trap        (trap),
        .quotient    (quotient),
        .remainder   (remainder)
    );

    // ---------------- behavioural reference ----------------
    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;
    string       cur_req = "R10";
    int          cd = 0;
    logic        exp_busy = 1'b0, exp_done = 1'b0, exp_trap = 1'b0;
    logic [15:0] exp_q = '0, exp_r = '0;
    logic        pend_ovf = 1'b0;
    logic [15:0] pend_q = '0, pend_r = '0;
    longint      m_a, m_b, m_qt, m_rt, m_lim;

    always @(posedge clk) begin
        if (!rst_n) begin
            cd = 0; exp_busy = 0; exp_done = 0; exp_trap = 0; exp_q = '0; exp_r = '0;
        end else begin
            exp_done = 0;
            exp_trap = 0;
            if (cd > 0) begin
                cd = cd - 1;
                if (cd == 0) begin
                    if (pend_ovf) exp_trap = 1;
                    else begin exp_done = 1; exp_q = pend_q; exp_r = pend_r; end
                end
            end else if (start) begin
                if (wide) begin
                    m_a = longint'($signed({dividend_hi, dividend_lo}));
                    m_b = longint'($signed(divisor));
                    m_lim = 32767;
                end else begin
                    m_a = longint'($signed({dividend_hi[7:0], dividend_lo[7:0]}));
                    m_b = longint'($signed(divisor[7:0]));
                    m_lim = 127;
                end
                if (m_b == 0) begin
                    exp_trap = 1;
                end else begin
                    m_qt = m_a / m_b;
                    m_rt = m_a % m_b;
                    pend_ovf = (m_qt > m_lim) || (m_qt < -m_lim);
                    pend_q = wide ? 16'(m_qt) : {8'h00, 8'(m_qt)};
                    pend_r = wide ? 16'(m_rt) : {8'h00, 8'(m_rt)};
                    cd = (wide ? 16 : 8) + 1;
                end
            end
            exp_busy = (cd > 0);
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (busy !== exp_busy || done !== exp_done || trap !== exp_trap ||
            quotient !== exp_q || remainder !== exp_r) begin
            fails++;
            $display("FAIL %s t=%0t actual busy=%0b done=%0b trap=%0b q=%h r=%h expected busy=%0b done=%0b trap=%0b q=%h r=%h",
                     cur_req, $time, busy, done, trap, quotient, remainder,
                     exp_busy, exp_done, exp_trap, exp_q, exp_r);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=still running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_idle();
        while (busy) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic launch(input logic w, input logic [15:0] hi, input logic [15:0] lo,
                          input logic [15:0] d, input string req);
        @(posedge clk); #2;
        wait_idle();
        cur_req = req;
        wide = w; dividend_hi = hi; dividend_lo = lo; divisor = d; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        wait_idle();
    endtask

    // Narrow operands with junk in the unused upper bytes (R1)
    task automatic run_narrow(input int v, input int d, input string req);
        launch(1'b0, {8'hA5, 8'(v >> 8)}, {8'h3C, 8'(v)}, {8'h5A, 8'(d)}, req);
    endtask

    task automatic run_wide(input int v, input int d, input string req);
        launch(1'b1, 16'(v >> 16), 16'(v), 16'(d), req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;           // R10: reset values checked every cycle
        repeat (2) @(posedge clk);

        run_narrow(100, 7, "R1");
        run_narrow(-100, 7, "R3");
        run_narrow(100, -7, "R3");
        run_narrow(-100, -7, "R3");
        run_narrow(5, 9, "R1");
        run_wide(1000000, 300, "R2");
        run_wide(-1000000, 300, "R3");
        run_wide(1000000, -301, "R3");
        run_wide(32767*5 + 4, 5, "R7");
        run_narrow(254, 2, "R4");       // +127 allowed
        run_narrow(-254, 2, "R4");      // -127 allowed
        run_narrow(-256, 2, "R4");      // -128 traps
        run_wide(12345, 10, "R6");
        run_narrow(256, 2, "R6");       // +128 traps, outputs held
        run_wide(-65534, 2, "R4");      // -32767 allowed
        run_wide(-65536, 2, "R4");      // -32768 traps
        run_wide(32'h7FFFFFFF, 1, "R4");
        run_wide(32'h80000000, -1, "R4");
        run_narrow(-32768, -1, "R4");
        run_wide(777, 0, "R5");
        launch(1'b0, 16'h0012, 16'h0034, 16'h0100, "R5");  // narrow zero divisor
        launch(1'b1, 16'h0000, 16'h0300, 16'h0100, "R2");  // same divisor, wide: 3

        // R8: back-to-back zero-divisor traps
        @(posedge clk); #2;
        cur_req = "R8";
        wide = 1'b1; dividend_hi = 16'h0001; dividend_lo = 16'h0000; divisor = 16'h0000;
        start = 1'b1;
        repeat (3) begin @(posedge clk); #2; end
        start = 1'b0;

        // R9: start held through the run and past the finishing edge
        @(posedge clk); #2;
        cur_req = "R9";
        wide = 1'b0; dividend_hi = 16'h00FF; dividend_lo = 16'h009C; divisor = 16'h0005;
        start = 1'b1;
        @(posedge clk); #2;
        wide = 1'b1; dividend_hi = 16'h0000; dividend_lo = 16'h4E20; divisor = 16'hFFF6;
        wait_idle();
        @(posedge clk); #2;
        start = 1'b0;
        wait_idle();
        repeat (3) @(posedge clk);
        #1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule